// File: doc/BRIEF.md
# PCI Power-State Transition Controller

This block follows the device power state of a PCI network controller. It has five states: an on-state that has not yet been set up, an on-state that has been initialized, a hot low-power state, a cold low-power state held up by the auxiliary supply, and fully off. Four inputs decide the moves between them: the bus reset, the two-bit power-state field that the host writes, the auxiliary-supply detect and the main power-good.

From the current state the block drives the request to power down the PHY and a one-cycle PHY reset. It also drives a clock/PLL disable and the memory/IO access enable, and it issues a one-cycle transition reset when the device leaves the hot low-power state. A wake-enable input is sampled when the device enters the hot low-power state. If it is set, the PHY keeps running so that wake events can still be detected, and the wake qualification output is asserted.

Top module: `pci_pm_ctrl`

## Requirements
- R1: After the asynchronous reset, `state_o` is 0 (uninitialized on-state) and every other output is low. From state 0, a cycle with `bus_reset_i` low and `pwr_good_i` high moves the block to state 1 (initialized on-state) at the next edge.
- R2: In state 1, with `bus_reset_i` low and power good, the block moves to state 2 (hot low-power) one edge after `pm_field_i` reads 3 (low power), provided it read 0 (on) in the cycle before.
- R3: On the move from state 1 to state 2 with `wake_en_i` low, `phy_pd_o` goes high and `phy_rst_o` pulses for one cycle. With `wake_en_i` high, neither output asserts and `wake_qual_o` goes high.
- R4: `clk_dis_o` is high in states 2, 3 and 4 and low in states 0 and 1. `mem_io_en_o` is high only in state 1.
- R5: In state 2 with power good, a change of `pm_field_i` from 3 to 0 moves the block to state 0. `xfer_rst_o` is then high for exactly one cycle, and `phy_pd_o` is released.
- R6: In state 1, `bus_reset_i` high with power good moves the block to state 0 at the next edge.
- R7: `pwr_good_i` low with `aux_det_i` high moves the block from state 0, 1 or 2 to state 3 (cold low-power). Coming from state 0 or 1, `phy_pd_o` is set and `phy_rst_o` pulses. Coming from state 2, the PHY and wake outputs keep their values.
- R8: `pwr_good_i` and `aux_det_i` both low move the block to state 4 (off) from any state. This sets `phy_pd_o` and clears `wake_qual_o`. The move takes priority over every other transition.
- R9: In state 3 or 4, `pwr_good_i` high moves the block to state 0. `phy_pd_o` and `wake_qual_o` are then cleared.
- R10: A change of `pm_field_i` that is not from 0 to 3 (in state 1) or from 3 to 0 (in state 2) leaves the state unchanged. For example, 0 then 1 then 3 does not enter state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| bus_reset_i | input | 1 | Bus reset, active high |
| pm_field_i | input | 2 | Host power-state field, 0 = on, 3 = low power |
| aux_det_i | input | 1 | Auxiliary supply present |
| pwr_good_i | input | 1 | Main power good |
| wake_en_i | input | 1 | Wake-event enable |
| state_o | output | 3 | Current state, encoded 0..4 |
| phy_pd_o | output | 1 | PHY general power-down request |
| phy_rst_o | output | 1 | One-cycle PHY reset |
| clk_dis_o | output | 1 | PLL and derived clocks disabled |
| mem_io_en_o | output | 1 | Memory and IO accesses answered |
| xfer_rst_o | output | 1 | One-cycle transition reset |
| wake_qual_o | output | 1 | Wake detection qualified |

## Verification
The properties assume that all inputs are synchronous to `clk_i` and hold steady across each edge. They also assume that the power-state field takes its low-power meaning only through a 0-to-3 step observed over two consecutive cycles. The stimulus changes inputs only one time unit after a rising edge. It reaches every state from reset through a fixed path and then applies each of the 64 input combinations once from that state, so every combination of start state and inputs is visited from a known history.

// File: rtl/pci_pm_pkg.sv
package pci_pm_pkg;
  localparam int PM_W = 2;
  localparam int ST_W = 3;
  localparam logic [PM_W-1:0] PM_ON  = '0;
  localparam logic [PM_W-1:0] PM_LOW = '1;

  typedef enum logic [ST_W-1:0] {
    PS_ON_UNINIT = 3'd0,
    PS_ON_INIT   = 3'd1,
    PS_LP_HOT    = 3'd2,
    PS_LP_COLD   = 3'd3,
    PS_OFF       = 3'd4
  } pwr_st_e;
endpackage

// File: rtl/pci_pm_field_edge.sv
module pci_pm_field_edge
  import pci_pm_pkg::*;
#(
  parameter int W = PM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] field_i,
  output logic         to_low_o,
  output logic         to_on_o
);
  localparam logic [W-1:0] ON_V  = '0;
  localparam logic [W-1:0] LOW_V = '1;

  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= ON_V;
    else         prev_q <= field_i;
  end

  assign to_low_o = (prev_q == ON_V)  && (field_i == LOW_V);
  assign to_on_o  = (prev_q == LOW_V) && (field_i == ON_V);
endmodule

// File: rtl/pci_pm_fsm.sv
module pci_pm_fsm
  import pci_pm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    bus_reset_i,
  input  logic    aux_det_i,
  input  logic    pwr_good_i,
  input  logic    to_low_i,
  input  logic    to_on_i,
  output pwr_st_e state_q_o,
  output pwr_st_e state_d_o
);
  pwr_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!pwr_good_i && !aux_det_i) begin
      st_d = PS_OFF;
    end else if (!pwr_good_i && aux_det_i &&
                 (st_q == PS_ON_UNINIT || st_q == PS_ON_INIT || st_q == PS_LP_HOT)) begin
      st_d = PS_LP_COLD;
    end else begin
      unique case (st_q)
        PS_ON_UNINIT: if (pwr_good_i && !bus_reset_i) st_d = PS_ON_INIT;
        PS_ON_INIT: begin
          if (bus_reset_i)   st_d = PS_ON_UNINIT;
          else if (to_low_i) st_d = PS_LP_HOT;
        end
        PS_LP_HOT:  if (to_on_i) st_d = PS_ON_UNINIT;
        PS_LP_COLD, PS_OFF: if (pwr_good_i) st_d = PS_ON_UNINIT;
        default:    st_d = PS_ON_UNINIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PS_ON_UNINIT;
    else         st_q <= st_d;
  end

  assign state_q_o = st_q;
  assign state_d_o = st_d;
endmodule

// File: rtl/pci_pm_out.sv
module pci_pm_out
  import pci_pm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pwr_st_e state_q_i,
  input  pwr_st_e state_d_i,
  input  logic    wake_en_i,
  output logic    phy_pd_o,
  output logic    phy_rst_o,
  output logic    clk_dis_o,
  output logic    mem_io_en_o,
  output logic    xfer_rst_o,
  output logic    wake_qual_o
);
  logic hold_q, prst_q, xrst_q, wake_q;
  logic hot_entry, hold_set, hold_clr, leave_hot_on;

  always_comb begin
    hot_entry    = (state_q_i == PS_ON_INIT) && (state_d_i == PS_LP_HOT);
    leave_hot_on = (state_q_i == PS_LP_HOT)  && (state_d_i == PS_ON_UNINIT);
    hold_clr     = (state_d_i == PS_ON_UNINIT) && (state_q_i != PS_ON_UNINIT);
    hold_set     = (hot_entry && !wake_en_i)
                || ((state_d_i == PS_LP_COLD) &&
                    (state_q_i == PS_ON_UNINIT || state_q_i == PS_ON_INIT))
                || ((state_d_i == PS_OFF) && (state_q_i != PS_OFF));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      prst_q <= 1'b0;
      xrst_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      prst_q <= hold_set;
      xrst_q <= leave_hot_on;
      if (hold_set)      hold_q <= 1'b1;
      else if (hold_clr) hold_q <= 1'b0;
      if (hot_entry)                                 wake_q <= wake_en_i;
      else if (hold_clr || state_d_i == PS_OFF)      wake_q <= 1'b0;
    end
  end

  assign phy_pd_o    = hold_q;
  assign phy_rst_o   = prst_q;
  assign xfer_rst_o  = xrst_q;
  assign wake_qual_o = wake_q;
  assign clk_dis_o   = (state_q_i != PS_ON_UNINIT) && (state_q_i != PS_ON_INIT);
  assign mem_io_en_o = (state_q_i == PS_ON_INIT);
endmodule

// File: rtl/pci_pm_ctrl.sv
module pci_pm_ctrl
  import pci_pm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_reset_i,
  input  logic [PM_W-1:0] pm_field_i,
  input  logic            aux_det_i,
  input  logic            pwr_good_i,
  input  logic            wake_en_i,
  output logic [ST_W-1:0] state_o,
  output logic            phy_pd_o,
  output logic            phy_rst_o,
  output logic            clk_dis_o,
  output logic            mem_io_en_o,
  output logic            xfer_rst_o,
  output logic            wake_qual_o
);
  logic    to_low, to_on;
  pwr_st_e st_q, st_d;

  pci_pm_field_edge #(.W(PM_W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .field_i  (pm_field_i),
    .to_low_o (to_low),
    .to_on_o  (to_on)
  );

  pci_pm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .aux_det_i   (aux_det_i),
    .pwr_good_i  (pwr_good_i),
    .to_low_i    (to_low),
    .to_on_i     (to_on),
    .state_q_o   (st_q),
    .state_d_o   (st_d)
  );

  pci_pm_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_q_i   (st_q),
    .state_d_i   (st_d),
    .wake_en_i   (wake_en_i),
    .phy_pd_o    (phy_pd_o),
    .phy_rst_o   (phy_rst_o),
    .clk_dis_o   (clk_dis_o),
    .mem_io_en_o (mem_io_en_o),
    .xfer_rst_o  (xfer_rst_o),
    .wake_qual_o (wake_qual_o)
  );

  assign state_o = st_q;
endmodule

// File: rtl/pci_pm_ctrl_chk.sv
module pci_pm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_reset_i,
  input logic [1:0] pm_field_i,
  input logic       aux_det_i,
  input logic       pwr_good_i,
  input logic       wake_en_i,
  input logic [2:0] state_o,
  input logic       phy_pd_o,
  input logic       phy_rst_o,
  input logic       clk_dis_o,
  input logic       mem_io_en_o,
  input logic       xfer_rst_o,
  input logic       wake_qual_o
);
  AST_ENTER_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && !bus_reset_i && pwr_good_i && $past(pm_field_i) == 2'd0 &&
     pm_field_i == 2'd3) |=> state_o == 3'd2); // R2
  AST_HOT_NO_WAKE_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && $past(pm_field_i) == 2'd0 && pm_field_i == 2'd3 && !bus_reset_i &&
     pwr_good_i && !wake_en_i) |=> (phy_pd_o && phy_rst_o)); // R3
  AST_WAKE_KEEPS_PHY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && wake_qual_o) |-> !phy_pd_o); // R3
  AST_HOT_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2) |-> (clk_dis_o && !mem_io_en_o)); // R4
  AST_XRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_rst_o |=> !xfer_rst_o); // R5
  AST_XRST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_rst_o) |-> (state_o == 3'd0 && $past(state_o) == 3'd2)); // R5
  AST_BUS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && bus_reset_i && pwr_good_i) |=> state_o == 3'd0); // R6
  AST_COLD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_good_i && aux_det_i && state_o <= 3'd2) |=> state_o == 3'd3); // R7
  AST_OFF_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_good_i && !aux_det_i) |=> (state_o == 3'd4 && phy_pd_o && !wake_qual_o)); // R8
  AST_STATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4); // R1
endmodule

bind pci_pm_ctrl pci_pm_ctrl_chk u_chk (.*);

// File: tb/pci_pm_ctrl_bench.sv
module pci_pm_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_reset_i = 1'b1;
  logic [1:0] pm_field_i = 2'd0;
  logic       aux_det_i = 1'b1;
  logic       pwr_good_i = 1'b1;
  logic       wake_en_i = 1'b0;
  logic [2:0] state_o;
  logic       phy_pd_o, phy_rst_o, clk_dis_o, mem_io_en_o, xfer_rst_o, wake_qual_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int  m_st = 0;
  bit  m_hold, m_prst, m_xrst, m_wake;
  logic [1:0] m_prev = 2'd0;

  always #5 clk_i = ~clk_i;

  pci_pm_ctrl u_pci_pm_ctrl (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int  nx = m_st;
    bit  hot_in, set, clr;
    bit  lo = (m_prev == 2'd0) && (pm_field_i == 2'd3);
    bit  on = (m_prev == 2'd3) && (pm_field_i == 2'd0);
    if (!pwr_good_i && !aux_det_i) nx = 4;
    else if (!pwr_good_i && aux_det_i && m_st <= 2) nx = 3;
    else case (m_st)
      0: if (pwr_good_i && !bus_reset_i) nx = 1;
      1: if (bus_reset_i) nx = 0; else if (lo) nx = 2;
      2: if (on) nx = 0;
      default: if (pwr_good_i) nx = 0;
    endcase
    hot_in = (m_st == 1) && (nx == 2);
    clr    = (nx == 0) && (m_st != 0);
    set    = (hot_in && !wake_en_i) || (nx == 3 && m_st <= 1) || (nx == 4 && m_st != 4);
    m_prst = set;
    m_xrst = (m_st == 2) && (nx == 0);
    if (set) m_hold = 1'b1; else if (clr) m_hold = 1'b0;
    if (hot_in) m_wake = wake_en_i; else if (clr || nx == 4) m_wake = 1'b0;
    m_prev = pm_field_i;
    m_st   = nx;
  endtask

  task automatic step();
    model_step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    bus_reset_i = 1'b1; pm_field_i = 2'd0; aux_det_i = 1'b1; pwr_good_i = 1'b1; wake_en_i = 1'b0;
    m_st = 0; m_hold = 0; m_prst = 0; m_xrst = 0; m_wake = 0; m_prev = 2'd0;
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
  endtask

  task automatic goto_state(int s);
    if (s == 0) return;
    bus_reset_i = 1'b0; step();                          // -> 1
    if (s == 2) begin pm_field_i = 2'd3; step(); end
    if (s == 3) begin pwr_good_i = 1'b0; step(); end
    if (s == 4) begin pwr_good_i = 1'b0; aux_det_i = 1'b0; step(); end
  endtask

  task automatic cmp_all(string tag);
    chk({tag, " state"},   state_o,     m_st);
    chk({tag, " phy_pd"},  phy_pd_o,    m_hold);
    chk({tag, " phy_rst"}, phy_rst_o,   m_prst);
    chk({tag, " xfer"},    xfer_rst_o,  m_xrst);
    chk({tag, " wake"},    wake_qual_o, m_wake);
    chk({tag, " clkdis"},  clk_dis_o,   int'(m_st >= 2));
    chk({tag, " memio"},   mem_io_en_o, int'(m_st == 1));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 outputs", {phy_pd_o, phy_rst_o, clk_dis_o, mem_io_en_o, xfer_rst_o, wake_qual_o}, 0);
    bus_reset_i = 1'b0; step();
    chk("R1 to init", state_o, 1);
    chk("R4 memio in init", mem_io_en_o, 1);
    // R10 non-adjacent field change ignored
    pm_field_i = 2'd1; step();
    chk("R10 field 1", state_o, 1);
    pm_field_i = 2'd3; step();
    chk("R10 field 1->3", state_o, 1);
    pm_field_i = 2'd0; step();
    // R2/R3 enter hot without wake
    pm_field_i = 2'd3; step();
    chk("R2 hot", state_o, 2);
    chk("R3 phy_pd", phy_pd_o, 1);
    chk("R3 phy_rst", phy_rst_o, 1);
    chk("R4 clkdis hot", clk_dis_o, 1);
    chk("R4 memio hot", mem_io_en_o, 0);
    step();
    chk("R3 phy_rst one cycle", phy_rst_o, 0);
    // R5 back to on with transition reset
    pm_field_i = 2'd0; step();
    chk("R5 state", state_o, 0);
    chk("R5 xfer pulse", xfer_rst_o, 1);
    chk("R5 phy released", phy_pd_o, 0);
    step();
    chk("R5 xfer one cycle", xfer_rst_o, 0);
    chk("R1 reinit", state_o, 1);
    // R3 with wake enabled
    wake_en_i = 1'b1; pm_field_i = 2'd3; step();
    chk("R3 wake hot", state_o, 2);
    chk("R3 wake phy_pd", phy_pd_o, 0);
    chk("R3 wake phy_rst", phy_rst_o, 0);
    chk("R3 wake qual", wake_qual_o, 1);
    // R7 hot -> cold keeps wake
    pwr_good_i = 1'b0; step();
    chk("R7 cold", state_o, 3);
    chk("R7 wake kept", wake_qual_o, 1);
    chk("R7 phy kept", phy_pd_o, 0);
    // R9 power back
    pwr_good_i = 1'b1; pm_field_i = 2'd0; wake_en_i = 1'b0; step();
    chk("R9 state", state_o, 0);
    chk("R9 wake clr", wake_qual_o, 0);
    step();
    // R6 bus reset in init
    bus_reset_i = 1'b1; step();
    chk("R6 state", state_o, 0);
    bus_reset_i = 1'b0; step();
    // R7 from init
    pwr_good_i = 1'b0; step();
    chk("R7 from init", state_o, 3);
    chk("R7 phy_pd", phy_pd_o, 1);
    chk("R7 phy_rst", phy_rst_o, 1);
    // R8 off
    aux_det_i = 1'b0; step();
    chk("R8 off", state_o, 4);
    chk("R8 phy_pd", phy_pd_o, 1);
    pwr_good_i = 1'b1; aux_det_i = 1'b1; step();
    chk("R9 from off", state_o, 0);
    chk("R9 phy clr", phy_pd_o, 0);

    // sweep: every start state x every input combination
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 64; c++) begin
        do_reset();
        goto_state(s);
        {wake_en_i, bus_reset_i, pm_field_i, aux_det_i, pwr_good_i} = 6'(c);
        step();
        cmp_all($sformatf("SWEEP s%0d c%0d", s, c));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule